// File: doc/BRIEF.md
# Cached-route arbitration controller

This controller sits on one output port of a network switch and decides which input drives that output through the crossbar. It has two ways of doing this. In normal operation it arbitrates round-robin for each packet. The winning input holds the output until its packet ends. An input can also open a cached route over a side control link. The crossbar connection then stays closed across packets, so later packets from that input pass with no arbitration at all. The connection itself is the only record of the route.

Each input has its own side-link request and acknowledge pair, plus a disconnect request and acknowledge pair. A connect request is granted only when the output is idle, or when the output is already cached for the same input. The owner of a cached route can reserve it, which locks out disconnection by other inputs, and can later release it. Changes to the connection are applied only when no packet is crossing the output. A teardown waits until the owner's request is low. A connect waits until a normal packet has finished.

Top module: `cached_route_ctl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, sel_o, cached_o, reserved_o, conn_ack_o and disc_ack_o are all zero.
- R2: With the output idle (sel_o zero), any req_i set and no conn_req_i set, the next cycle sel_o is one-hot on a requesting input. The search starts at the input after the last normally granted one and wraps. After reset the search starts at input 0.
- R3: A normal grant stays on its input until a cycle in which that input has both req_i and eop_i set. In the cycle after that, sel_o is zero.
- R4: In idle, conn_req_i takes precedence over req_i. The lowest-index connecting input gets a one-cycle conn_ack_o pulse on its own bit in the next cycle, together with sel_o on that input and cached_o=1.
- R5: A connect request from the current cached owner is acknowledged again with no change to the route. A connect request from any other input gets no acknowledge while a route is cached or a normal packet is in progress.
- R6: While cached_o stays 1, sel_o stays on the owner whatever req_i does. The owner's packets need no arbitration cycle, and other inputs' req_i have no effect.
- R7: A cached route is torn down only in a cycle where the owner's req_i is low. In the next cycle the requester gets a disc_ack_o pulse, and sel_o and cached_o are zero.
- R8: rsv_i from the cached owner sets reserved_o in the next cycle. rel_i from the owner clears it, and rel_i wins if both are set. Both are ignored from other inputs and when no route is cached. Teardown clears reserved_o.
- R9: While reserved_o is 1, a disconnect from a non-owner gets no acknowledge and the route stays. Without a reservation, a non-owner disconnect is accepted under the R7 timing.
- R10: A disconnect request when no route is cached is acknowledged in the next cycle and changes nothing else.
- R11: Normal requests left pending while a route is cached are granted in the cycle after teardown, under the R2 order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Switch clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_IN | Per-input packet request for this output |
| eop_i | input | NUM_IN | Per-input last-phit marker, valid with req_i |
| conn_req_i | input | NUM_IN | Side-link cached-route connect request |
| disc_req_i | input | NUM_IN | Side-link disconnect request |
| rsv_i | input | NUM_IN | Reserve the cached route (owner only) |
| rel_i | input | NUM_IN | Release a reservation (owner only) |
| sel_o | output | NUM_IN | One-hot crossbar select, zero when idle |
| cached_o | output | 1 | A cached route holds the output |
| reserved_o | output | 1 | The cached route is reserved |
| conn_ack_o | output | NUM_IN | Connect acknowledge pulse |
| disc_ack_o | output | NUM_IN | Disconnect acknowledge pulse |

## Verification
The properties assume only that eop_i matters when it comes with req_i. Every other input may take any value in any cycle, because the controller has to stay safe even when side-link requests are held, repeated or raised at the same time. The random phase therefore drives all inputs freely. Packet requests are dense, and connect, disconnect, reserve and release are kept sparse, so that cached routes last long enough to be reserved, disputed and torn down. Directed sequences first place each contested case at a known cycle.

// File: rtl/cached_route_pkg.sv
package cached_route_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NORM   = 2'd1,
    ST_CACHED = 2'd2
  } route_st_e;
endpackage

// File: rtl/crr_prio_pick.sv
// Lowest index wins; serves the side-link connect arbiter.
module crr_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] seen;
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign seen[i] = 1'b0;
    end else begin : g_rest
      assign seen[i] = seen[i-1] | req_i[i-1];
    end
    assign gnt_o[i] = req_i[i] & ~seen[i];
  end
endmodule

// File: rtl/crr_rr_arb.sv
// Round-robin pick starting after ptr_i.
module crr_rr_arb #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    int   idx;
    gnt_o = '0;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(ptr_i) + off) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/crr_oh_idx.sv
module crr_oh_idx #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] oh_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_i[i]) idx_o = idx_o | W'(i);
    end
  end
endmodule

// File: rtl/cached_route_ctl.sv
module cached_route_ctl
  import cached_route_pkg::*;
#(
  parameter int NUM_IN = 4,
  localparam int W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] req_i,
  input  logic [NUM_IN-1:0] eop_i,
  input  logic [NUM_IN-1:0] conn_req_i,
  input  logic [NUM_IN-1:0] disc_req_i,
  input  logic [NUM_IN-1:0] rsv_i,
  input  logic [NUM_IN-1:0] rel_i,
  output logic [NUM_IN-1:0] sel_o,
  output logic              cached_o,
  output logic              reserved_o,
  output logic [NUM_IN-1:0] conn_ack_o,
  output logic [NUM_IN-1:0] disc_ack_o
);
  route_st_e         st_q, st_d;
  logic [W-1:0]      owner_q, owner_d, ptr_q, ptr_d;
  logic              rsv_q, rsv_d;
  logic [NUM_IN-1:0] cack_q, cack_d, dack_q, dack_d;

  logic [NUM_IN-1:0] owner_oh, conn_oh, rr_oh, disc_ok;
  logic [W-1:0]      conn_idx, rr_idx;
  logic              owner_req, owner_eop;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_own
    assign owner_oh[i] = (owner_q == W'(i));
  end
  assign owner_req = |(req_i & owner_oh);
  assign owner_eop = |(eop_i & owner_oh);

  // Small side arbiter for the cached path, beside the packet arbiter
  crr_prio_pick #(.N(NUM_IN)) u_conn_pick (.req_i(conn_req_i), .gnt_o(conn_oh));
  crr_oh_idx    #(.N(NUM_IN)) u_conn_idx  (.oh_i(conn_oh), .idx_o(conn_idx));
  crr_rr_arb    #(.N(NUM_IN)) u_rr        (.req_i(req_i), .ptr_i(ptr_q), .gnt_o(rr_oh));
  crr_oh_idx    #(.N(NUM_IN)) u_rr_idx    (.oh_i(rr_oh), .idx_o(rr_idx));

  // Teardown only when the owner has no packet crossing
  assign disc_ok = disc_req_i & (rsv_q ? owner_oh : {NUM_IN{1'b1}}) & {NUM_IN{~owner_req}};

  always_comb begin
    st_d    = st_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    rsv_d   = rsv_q;
    cack_d  = '0;
    dack_d  = '0;
    unique case (st_q)
      ST_IDLE: begin
        dack_d = disc_req_i;
        if (|conn_req_i) begin
          st_d           = ST_CACHED;
          owner_d        = conn_idx;
          rsv_d          = 1'b0;
          cack_d         = conn_oh;
        end else if (|req_i) begin
          st_d    = ST_NORM;
          owner_d = rr_idx;
          ptr_d   = rr_idx;
        end
      end
      ST_NORM: begin
        dack_d = disc_req_i;
        if (owner_req && owner_eop) st_d = ST_IDLE;
      end
      ST_CACHED: begin
        if (|disc_ok) begin
          dack_d = disc_ok;
          st_d   = ST_IDLE;
          rsv_d  = 1'b0;
        end else begin
          cack_d = conn_req_i & owner_oh;
          if (|(rel_i & owner_oh))      rsv_d = 1'b0;
          else if (|(rsv_i & owner_oh)) rsv_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      owner_q <= '0;
      ptr_q   <= W'(NUM_IN - 1);
      rsv_q   <= 1'b0;
      cack_q  <= '0;
      dack_q  <= '0;
    end else begin
      st_q    <= st_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
      rsv_q   <= rsv_d;
      cack_q  <= cack_d;
      dack_q  <= dack_d;
    end
  end

  assign sel_o      = (st_q != ST_IDLE) ? owner_oh : '0;
  assign cached_o   = (st_q == ST_CACHED);
  assign reserved_o = rsv_q;
  assign conn_ack_o = cack_q;
  assign disc_ack_o = dack_q;
endmodule

// File: rtl/cached_route_chk.sv
module cached_route_chk #(
  parameter int NUM_IN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_IN-1:0] req_i,
  input logic [NUM_IN-1:0] eop_i,
  input logic [NUM_IN-1:0] conn_req_i,
  input logic [NUM_IN-1:0] sel_o,
  input logic              cached_o,
  input logic              reserved_o,
  input logic [NUM_IN-1:0] conn_ack_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R2
  AST_IDLE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0 && |req_i && !(|conn_req_i)) |=> (sel_o != '0)); // R11
  AST_PKT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(|(sel_o & req_i & ~eop_i)) && !$past(cached_o)) |-> (sel_o == $past(sel_o))); // R3
  AST_CONN_ACK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(conn_ack_o)); // R4
  AST_ACK_ON_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|conn_ack_o) |-> (cached_o && sel_o == conn_ack_o)); // R5
  AST_CACHED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cached_o && $past(cached_o)) |-> (sel_o == $past(sel_o))); // R6
  AST_TEAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cached_o) |-> !$past(|(sel_o & req_i))); // R7
  AST_RSV_CACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved_o |-> cached_o); // R8
endmodule

bind cached_route_ctl cached_route_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .eop_i(eop_i),
  .conn_req_i(conn_req_i), .sel_o(sel_o), .cached_o(cached_o),
  .reserved_o(reserved_o), .conn_ack_o(conn_ack_o)
);

// File: tb/cached_route_ctl_tb.sv
module cached_route_ctl_tb;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] req_i = '0, eop_i = '0, conn_req_i = '0, disc_req_i = '0, rsv_i = '0, rel_i = '0;
  logic [N-1:0] sel_o, conn_ack_o, disc_ack_o;
  logic cached_o, reserved_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state: 0 idle, 1 normal, 2 cached
  int m_st = 0, m_own = 0, m_ptr = N - 1;
  bit m_rsv = 0;
  logic [N-1:0] m_cack = '0, m_dack = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cached_route_ctl #(.NUM_IN(N)) u_dut (.*);

  function automatic int rr_pick(int ptr, logic [N-1:0] r);
    for (int off = 1; off <= N; off++) begin
      if (r[(ptr + off) % N]) return (ptr + off) % N;
    end
    return 0;
  endfunction

  function automatic int low_pick(logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return 0;
  endfunction

  task automatic model_update();
    logic [N-1:0] allow, ok;
    m_cack = '0; m_dack = '0;
    case (m_st)
      0: begin
        m_dack = disc_req_i;
        if (|conn_req_i) begin
          m_own = low_pick(conn_req_i); m_st = 2; m_rsv = 0; m_cack[m_own] = 1'b1;
        end else if (|req_i) begin
          m_own = rr_pick(m_ptr, req_i); m_ptr = m_own; m_st = 1;
        end
      end
      1: begin
        m_dack = disc_req_i;
        if (req_i[m_own] && eop_i[m_own]) m_st = 0;
      end
      default: begin
        allow = m_rsv ? (N'(1) << m_own) : '1;
        ok = req_i[m_own] ? '0 : (disc_req_i & allow);
        if (|ok) begin
          m_dack = ok; m_st = 0; m_rsv = 0;
        end else begin
          m_cack[m_own] = conn_req_i[m_own];
          if (rel_i[m_own]) m_rsv = 0;
          else if (rsv_i[m_own]) m_rsv = 1;
        end
      end
    endcase
  endtask

  task automatic compare(string tag);
    logic [N-1:0] e_sel;
    e_sel = (m_st != 0) ? (N'(1) << m_own) : '0;
    checks++;
    if (sel_o !== e_sel || cached_o !== (m_st == 2) || reserved_o !== m_rsv ||
        conn_ack_o !== m_cack || disc_ack_o !== m_dack) begin
      failures++;
      $display("FAIL %s: sel/cached/rsv/cack/dack actual %b %b %b %b %b expected %b %b %b %b %b",
               tag, sel_o, cached_o, reserved_o, conn_ack_o, disc_ack_o,
               e_sel, (m_st == 2), m_rsv, m_cack, m_dack);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic clr();
    req_i = '0; eop_i = '0; conn_req_i = '0; disc_req_i = '0; rsv_i = '0; rel_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20571));
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    step("R1 after reset");

    // R2 / R3: normal round robin and packet hold
    req_i = 4'b0110; step("R2 first grant from input0 order");
    step("R3 hold without eop");
    eop_i = 4'b0100; step("R3 eop on other input ignored");
    eop_i = 4'b0010; step("R3 release on eop");
    eop_i = '0; step("R2 rotate to next input");
    eop_i = 4'b0100; step("R3 release");
    clr();

    // R4: connect beats normal requests, lowest index wins
    req_i = 4'b1111; conn_req_i = 4'b1010; step("R4 connect in idle");
    conn_req_i = 4'b1000; step("R5 other input waits");
    step("R6 sel stays on owner");
    conn_req_i = 4'b0010; step("R5 owner reconnect acked");
    conn_req_i = '0; req_i = 4'b0001; step("R6 other req ignored");

    // R8 reserve / release
    rsv_i = 4'b0100; step("R8 non-owner reserve ignored");
    rsv_i = 4'b0010; step("R8 owner reserve");
    rsv_i = '0;

    // R9 reserved blocks non-owner disconnect
    req_i = 4'b1000; disc_req_i = 4'b1000; step("R9 reserved disconnect blocked");
    step("R9 still blocked");
    disc_req_i = 4'b0010; req_i = 4'b1010; step("R7 owner busy blocks teardown");
    req_i = 4'b1000; step("R7 teardown when owner quiet");
    disc_req_i = '0; step("R11 pending request granted");
    disc_req_i = 4'b0001; step("R10 disconnect with no route");
    disc_req_i = '0; eop_i = 4'b1000; step("R3 end packet");
    clr();

    // R9 unreserved non-owner disconnect accepted
    conn_req_i = 4'b0100; step("R4 connect input2");
    conn_req_i = '0; rsv_i = 4'b0100; rel_i = 4'b0100; step("R8 release wins");
    rsv_i = '0; rel_i = '0;
    disc_req_i = 4'b0001; step("R9 unreserved disconnect");
    disc_req_i = '0; rsv_i = 4'b0100; step("R8 reserve with no route ignored");
    rsv_i = '0;
    conn_req_i = 4'b0001; step("R4 connect input0");
    conn_req_i = '0; rsv_i = 4'b0001; step("R8 reserve");
    rsv_i = '0; rel_i = 4'b0001; step("R8 release");
    rel_i = '0; disc_req_i = 4'b0001; step("R7 owner disconnect");
    clr(); step("R1 idle");

    // random mix
    for (int c = 0; c < 4000; c++) begin
      req_i = N'($urandom);
      eop_i = N'($urandom) & N'($urandom);
      conn_req_i = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
      disc_req_i = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
      rsv_i = N'($urandom) & N'($urandom) & N'($urandom);
      rel_i = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
      step("R6 random mix");
    end
    clr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule